// File: doc/BRIEF.md
# Clock Generator Divider Control Bank

This block is the register file of a clock generator. Three frequency-select strap pins are captured while reset is held. The captured code indexes a small divider table that yields the feedback (N) and reference (R) words of the PLL, together with a two-bit CPU frequency code. Software can instead program its own N and R words and set an enable bit so that the PLL uses those values in place of the table.

The bank is reached through a plain byte port: address, write data, a write strobe, a read strobe and read data. A serial-bus slave front end drives this port. The port is control traffic with no flow control. Every strobe is accepted in the cycle it is sampled, so there is no back-pressure and no ready signal. The bank also holds a read-only identification byte and a reserved byte. Writes to either of these are taken and then discarded.

Top module: `clksyn_ctl_bank`

## Requirements
- R1: `cpu_freq` equals the captured select bits 1:0. 00 means 66 MHz, 01 means 100 MHz, 10 means 200 MHz and 11 means 133 MHz. Select bit 2 has no effect on `cpu_freq`.
- R2: The straps are sampled on every clock edge while `rst_n` is low and are frozen once `rst_n` is high. Later changes on the strap pins change no output.
- R3: If `strap_s2_mid` is high during capture, select bit 2 is captured as 0 whatever the level on `strap_sel[2]`.
- R4: While the dial-in enable is 0, the outputs come from the table. For codes 00, 01, 10 and 11, the base N is 14, 7, 14 and 28 and the base R is 3, 1, 1 and 3. A captured select bit 2 of 1 doubles both N and R.
- R5: Address 8 holds the programmed N in bits 6:0. Bit 7 always reads 0.
- R6: Address 9 holds the programmed R in bits 6:1 and the dial-in enable in bit 0. Bit 7 always reads 0.
- R7: While the enable is 1, `pll_n` and `pll_r` equal the programmed values. They update on the clock edge after the edge that captures the write, and never during the write edge itself.
- R8: Address 6 always reads 0x13, which is revision 1 in bits 7:4 and vendor 3 in bits 3:0. A write to it is accepted and has no effect.
- R9: Address 7 always reads 0x00, and a write to it has no effect.
- R10: Any other address reads 0x00. A write to such an address changes neither any output nor any stored byte.
- R11: Reset clears addresses 8 and 9 to 0x00 and clears `rd_data` to 0x00.
- R12: `rd_data` loads on the edge that samples `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset; straps are captured while it is low |
| strap_sel | input | 3 | Frequency-select strap pins, bit 2 down to bit 0 |
| strap_s2_mid | input | 1 | High when select bit 2 sits at a mid-level voltage |
| reg_addr | input | 4 | Byte address |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one byte per sampled cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, registered |
| pll_n | output | 7 | Selected N divider word |
| pll_r | output | 6 | Selected R divider word |
| cpu_freq | output | 2 | Decoded CPU frequency code |

## Verification
Read data is due one edge after the edge that samples `rd_en`. The bench raises the strobe at a falling edge and compares `rd_data` at the following falling edge. Divider outputs are due two edges after a write is presented: one edge to store the byte and one edge to register the selection. The bench checks that the old value is still present one edge after the write and that the new value appears one edge later. Strap-derived outputs load on the first edge after reset release. They are compared two edges after release, after the strap pins have already been disturbed.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int ADR_SIG  = 6;
  localparam int ADR_RSV  = 7;
  localparam int ADR_NDIV = 8;
  localparam int ADR_RDIV = 9;

  typedef struct packed {
    logic       s2;
    logic [1:0] fsel;
  } strap_t;

  function automatic logic [5:0] base_n(input logic [1:0] f);
    case (f)
      2'b00:   return 6'd14;
      2'b01:   return 6'd7;
      2'b10:   return 6'd14;
      default: return 6'd28;
    endcase
  endfunction

  function automatic logic [4:0] base_r(input logic [1:0] f);
    case (f)
      2'b00:   return 5'd3;
      2'b01:   return 5'd1;
      2'b10:   return 5'd1;
      default: return 5'd3;
    endcase
  endfunction

endpackage

// File: rtl/clksyn_strap_latch.sv
module clksyn_strap_latch
  import clkcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pins,
  input  logic       s2_mid,
  output strap_t     strap
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap.s2   <= pins[2] & ~s2_mid;
      strap.fsel <= pins[1:0];
    end
  end

endmodule

// File: rtl/clksyn_cfg_regs.sv
module clksyn_cfg_regs
  import clkcfg_pkg::*;
#(
  parameter int         ADDR_W = 4,
  parameter int         N_W    = 7,
  parameter int         R_W    = 6,
  parameter logic [3:0] REV    = 4'h1,
  parameter logic [3:0] VEN    = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [7:0]        rdata,
  output logic [N_W-1:0]    dial_n,
  output logic [R_W-1:0]    dial_r,
  output logic              dial_en
);

  localparam logic [ADDR_W-1:0] A_SIG = ADDR_W'(ADR_SIG);
  localparam logic [ADDR_W-1:0] A_RSV = ADDR_W'(ADR_RSV);
  localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(ADR_NDIV);
  localparam logic [ADDR_W-1:0] A_R   = ADDR_W'(ADR_RDIV);

  logic [7:0] rd_mux;
  logic       unused_wbit;
  assign unused_wbit = wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dial_n  <= '0;
      dial_r  <= '0;
      dial_en <= 1'b0;
    end else if (wr) begin
      if (addr == A_N) dial_n <= wdata[N_W-1:0];
      if (addr == A_R) begin
        dial_r  <= wdata[R_W:1];
        dial_en <= wdata[0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_SIG) rd_mux = {REV, VEN};
    else if (addr == A_N) rd_mux[N_W-1:0] = dial_n;
    else if (addr == A_R) begin
      rd_mux[R_W:1] = dial_r;
      rd_mux[0]     = dial_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  AST_SIG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_SIG) |=> rdata == {REV, VEN}); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_RSV) |=> rdata == 8'h00); // R9
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == A_N || addr == A_R)) |=> !rdata[7]); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr > A_R) |=> rdata == 8'h00); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R12

endmodule

// File: rtl/clksyn_div_select.sv
module clksyn_div_select
  import clkcfg_pkg::*;
#(
  parameter int N_W = 7,
  parameter int R_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  strap_t         strap,
  input  logic [N_W-1:0] dial_n,
  input  logic [R_W-1:0] dial_r,
  input  logic           dial_en,
  input  logic           wr_seen,
  output logic [N_W-1:0] pll_n,
  output logic [R_W-1:0] pll_r,
  output logic [1:0]     cpu_freq
);

  logic [N_W-1:0] rom_n;
  logic [R_W-1:0] rom_r;

  always_comb begin
    rom_n = N_W'(base_n(strap.fsel)) << strap.s2;
    rom_r = R_W'(base_r(strap.fsel)) << strap.s2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_n    <= '0;
      pll_r    <= '0;
      cpu_freq <= 2'b00;
    end else begin
      pll_n    <= dial_en ? dial_n : rom_n;
      pll_r    <= dial_en ? dial_r : rom_r;
      cpu_freq <= strap.fsel;
    end
  end

  AST_FREQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> $stable(cpu_freq)); // R2
  AST_DIV_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && !$past(wr_seen, 2)) |-> ($stable(pll_n) && $stable(pll_r))); // R7
  AST_TABLE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dial_en)) |-> (pll_n != '0 && pll_r != '0)); // R4

endmodule

// File: rtl/clksyn_ctl_bank.sv
module clksyn_ctl_bank
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_W    = 7,
  parameter int R_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_sel,
  input  logic              strap_s2_mid,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic [N_W-1:0]    pll_n,
  output logic [R_W-1:0]    pll_r,
  output logic [1:0]        cpu_freq
);

  strap_t         strap;
  logic [N_W-1:0] dial_n;
  logic [R_W-1:0] dial_r;
  logic           dial_en;

  clksyn_strap_latch u_strap (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (strap_sel),
    .s2_mid (strap_s2_mid),
    .strap  (strap)
  );

  clksyn_cfg_regs #(.ADDR_W(ADDR_W), .N_W(N_W), .R_W(R_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wdata   (wr_data),
    .wr      (wr_en),
    .rd      (rd_en),
    .rdata   (rd_data),
    .dial_n  (dial_n),
    .dial_r  (dial_r),
    .dial_en (dial_en)
  );

  clksyn_div_select #(.N_W(N_W), .R_W(R_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap    (strap),
    .dial_n   (dial_n),
    .dial_r   (dial_r),
    .dial_en  (dial_en),
    .wr_seen  (wr_en),
    .pll_n    (pll_n),
    .pll_r    (pll_r),
    .cpu_freq (cpu_freq)
  );

endmodule

// File: tb/clksyn_ctl_bank_test.sv
`timescale 1ns/1ps
module clksyn_ctl_bank_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_sel = 3'b000;
  logic       strap_s2_mid = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [6:0] pll_n;
  logic [5:0] pll_r;
  logic [1:0] cpu_freq;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clksyn_ctl_bank uut (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .strap_s2_mid(strap_s2_mid),
    .reg_addr(reg_addr), .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .pll_n(pll_n), .pll_r(pll_r), .cpu_freq(cpu_freq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int tbl_n(input int f, input int s2);
    int b;
    b = (f == 0) ? 14 : (f == 1) ? 7 : (f == 2) ? 14 : 28;
    return b << s2;
  endfunction

  function automatic int tbl_r(input int f, input int s2);
    int b;
    b = (f == 0 || f == 3) ? 3 : 1;
    return b << s2;
  endfunction

  task automatic wr_byte(input int a, input int d);
    @(negedge clk);
    reg_addr = 4'(a); wr_data = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_byte(input int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_reset(input int s, input int m);
    @(negedge clk);
    rst_n = 1'b0;
    strap_sel = 3'(s); strap_s2_mid = m[0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap_sel = ~3'(s); strap_s2_mid = ~m[0];
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int d, s2l, f, cur_n, cur_r;
    repeat (2) @(negedge clk);
    chk("R11 rd_data in reset", rd_data, 0);
    chk("R11 pll_n in reset", pll_n, 0);
    do_reset(0, 0);
    rd_byte(8, d); chk("R11 byte8 after reset", d, 0);
    rd_byte(9, d); chk("R11 byte9 after reset", d, 0);

    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 2; m++) begin
        do_reset(s, m);
        f = s & 3;
        s2l = ((s >> 2) & 1) & (1 - m);
        chk("R1 R2 cpu_freq", cpu_freq, f);
        chk("R3 R4 pll_n table", pll_n, tbl_n(f, s2l));
        chk("R3 R4 pll_r table", pll_r, tbl_r(f, s2l));
      end
    end

    do_reset(5, 0);
    cur_n = tbl_n(1, 1); cur_r = tbl_r(1, 1);
    for (int v = 0; v < 256; v++) begin
      wr_byte(8, v);
      @(negedge clk);
      rd_byte(8, d); chk("R5 byte8 readback", d, v & 8'h7f);
      chk("R4 pll_n table while disabled", pll_n, cur_n);
    end

    for (int v = 0; v < 256; v++) begin
      wr_byte(9, v);
      chk("R7 old pll_r one edge after write", pll_r, cur_r);
      @(negedge clk);
      if (v & 1) begin
        cur_n = 8'h7f; cur_r = (v >> 1) & 8'h3f;
      end else begin
        cur_n = tbl_n(1, 1); cur_r = tbl_r(1, 1);
      end
      chk("R7 pll_n selected", pll_n, cur_n);
      chk("R7 pll_r selected", pll_r, cur_r);
      rd_byte(9, d); chk("R6 byte9 readback", d, v & 8'h7f);
    end
    chk("R1 cpu_freq after writes", cpu_freq, 1);

    wr_byte(6, 8'hff);
    rd_byte(6, d); chk("R8 signature", d, 8'h13);
    wr_byte(7, 8'hff);
    rd_byte(7, d); chk("R9 reserved byte", d, 0);

    for (int a = 0; a < 16; a++) begin
      if (a < 6 || a > 9) begin
        wr_byte(a, 8'hff);
        @(negedge clk);
        rd_byte(a, d); chk("R10 unmapped read", d, 0);
        chk("R10 pll_n untouched", pll_n, cur_n);
        chk("R10 pll_r untouched", pll_r, cur_r);
        rd_byte(8, d); chk("R10 byte8 untouched", d, 8'h7f);
        rd_byte(9, d); chk("R10 byte9 untouched", d, 8'h7f);
      end
    end

    rd_byte(6, d);
    @(negedge clk); reg_addr = 4'd8;
    repeat (3) @(negedge clk);
    chk("R12 rd_data held without strobe", rd_data, 8'h13);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule